// File: doc/BRIEF.md
# SMBus Block-Read Target with Packet Error Code

This block is the target side of one fixed SMBus transaction: a block read of a fixed number of bytes. It watches the clock and data lines through synchronizers and never drives either line high. It only pulls data low through an output enable, leaving the pad to form the open-drain connection. A host first addresses the target for writing and sends the block-read command code. It then issues a repeated start and addresses the target again, this time for reading. The target answers with a byte count and the buffer contents, followed by a CRC-8 packet error code when that option is enabled.

The data bytes come from a storage array outside the block, through a simple combinational read port. The block presents an index, and the array returns the byte at that index in the same clock cycle. A host that sends any other address, direction or command is refused with a NACK. The block then stays silent until the next start condition. A stop, a new start or a host NACK in the middle of the read ends the response at once.

Top module: `smb_blkrd_target`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and `rd_addr` is 0.
- R2: After a start, the first byte is taken MSB first as {address[6:0], R/W}. The target ACKs it (holds the data line low during the 9th clock) only when the address equals `own_addr` and R/W = 0. In every other case it NACKs and drives nothing until the next start.
- R3: The second byte is acknowledged only when it is the command code 0xFD. Any other value gets a NACK, and the target stays silent through a following repeated start and address.
- R4: After the command, a repeated start followed by {`own_addr`, 1} is acknowledged. A different address, or R/W = 0, gets a NACK.
- R5: The first byte the target sends after the read address is the count 0x20, MSB first, with each bit changed only while the clock is low.
- R6: After the count, the target sends 32 data bytes. Data byte k (k = 0..31) is the value on `rd_data` while `rd_addr` = k.
- R7: When `pec_en` was 1 at the opening start, one more byte follows data byte 31. That byte is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) over the write-address byte, the command, the read-address byte, the count and the 32 data bytes.
- R8: When `pec_en` was 0 at the opening start, nothing follows data byte 31, so a further byte read by the host returns 0xFF.
- R9: A host NACK on any byte before the final one releases the data line for the rest of the transaction, so further bytes read as 0xFF.
- R10: A stop or a start in the middle of the response releases the data line at once. A start there begins a fresh transaction, which is then served in full.
- R11: The target changes its data-line drive only while the synchronized clock is low.
- R12: The CRC register is cleared at the opening start and kept across the repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SMBus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| own_addr | input | 7 | Target's 7-bit bus address |
| pec_en | input | 1 | Appends the CRC-8 byte; sampled at the opening start |
| rd_addr | output | 5 | Buffer index of the next data byte |
| rd_data | input | 8 | Buffer byte at `rd_addr`, valid in the same cycle |

## Verification
The assertions rely on the host changing the data line only while the clock is low, apart from start and stop conditions. They also rely on the host never issuing a start or stop while the target holds the line low, so a release can only fall in a low clock phase. Each clock phase must last long enough for the synchronizers and the drive register to settle before the next edge. The stimulus meets these conditions by using quarter periods of six system clocks and changing data only a quarter after a falling clock. Aborts are placed only where the target's current bit is a 1, that is, where the target is not pulling the line low.

// File: rtl/smb_blkrd_pkg.sv
// Shared types and constants for the SMBus block-read target.
// Assumes 7-bit addressing and byte-wide transfers, as SMBus fixes them.
package smb_blkrd_pkg;

    localparam int          TGT_ADDR_W = 7;
    localparam logic [7:0]  CRC8_POLY  = 8'h07;

    // Engine states: receive, acknowledge, wait for repeated start,
    // transmit, wait for host acknowledge, wait for next falling clock.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_WAIT_SR,
        ST_TX,
        ST_HACK,
        ST_NEXT
    } eng_state_e;

    // Which received byte is being taken in.
    typedef enum logic [1:0] {
        PH_ADDR_WR,
        PH_CMD,
        PH_ADDR_RD
    } rx_phase_e;

endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes the SMBus clock and data lines into the system clock
// domain and derives clock edges and start / stop conditions.
// Assumes STAGES >= 2 and a system clock at least 8x the bus clock.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q;
    logic       sda_q;

    assign raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Resynchronization chain; idle bus level is high.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // One-cycle history of both synchronized lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_crc8.sv
// Bit-serial CRC-8 accumulator, MSB first, initial value zero.
// Assumes clr and en are never needed in the same cycle (clr wins).
module smb_crc8
    import smb_blkrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);

    logic fb;
    assign fb = crc[7] ^ din;

    // Shift one bus bit into the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= 8'h00;
        else if (en)       crc <= {crc[6:0], 1'b0} ^ (fb ? CRC8_POLY : 8'h00);
    end

endmodule

// File: rtl/smb_blkrd_target.sv
// SMBus target that answers one block-read transaction: write address,
// command CMD_CODE, repeated start, read address, then the count,
// NUM_BYTES buffer bytes and an optional CRC-8 byte.
// Assumes the host changes data only while the clock is low (except
// start / stop), a system clock at least 8x the bus clock, and a buffer
// whose rd_data follows rd_addr within the same cycle. NUM_BYTES <= 32.
module smb_blkrd_target
    import smb_blkrd_pkg::*;
#(
    parameter int         NUM_BYTES   = 32,
    parameter logic [7:0] CMD_CODE    = 8'hFD,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_in,
    input  logic                         sda_in,
    output logic                         sda_oe,
    input  logic [TGT_ADDR_W-1:0]        own_addr,
    input  logic                         pec_en,
    output logic [$clog2(NUM_BYTES)-1:0] rd_addr,
    input  logic [7:0]                   rd_data
);

    localparam int         RA_W       = $clog2(NUM_BYTES);
    localparam int         IDX_W      = $clog2(NUM_BYTES + 3);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_BYTES);

    eng_state_e       state;
    rx_phase_e        phase;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic [IDX_W-1:0] idx;
    logic             pec_lat;
    logic             oe_q;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic             crc_clr, crc_en;
    logic [7:0]       crc_q;
    logic             rx_ok;
    logic [IDX_W-1:0] idx_final;
    logic [7:0]       next_byte;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    // CRC clears at an opening start and takes every byte bit on the bus.
    assign crc_clr = start_p && (state != ST_WAIT_SR);
    assign crc_en  = scl_rise && !start_p && !stop_p &&
                     (((state == ST_RX) && (bitcnt < 4'd8)) || (state == ST_TX));

    smb_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (sda_s),
        .crc   (crc_q)
    );

    // Decide whether the byte just received deserves an ACK.
    always_comb begin
        case (phase)
            PH_ADDR_WR: rx_ok = (shreg == {own_addr, 1'b0});
            PH_CMD:     rx_ok = (shreg == CMD_CODE);
            default:    rx_ok = (shreg == {own_addr, 1'b1});
        endcase
    end

    // Last byte index: count plus data, plus one when the CRC byte is on.
    assign idx_final = pec_lat ? IDX_W'(NUM_BYTES + 2) : IDX_W'(NUM_BYTES + 1);
    // Next outgoing byte: buffer data, then the CRC remainder.
    assign next_byte = (idx <= IDX_W'(NUM_BYTES)) ? rd_data : crc_q;
    assign rd_addr   = (idx == '0) ? '0 : RA_W'(idx - 1'b1);
    assign sda_oe    = oe_q;

    // Transaction engine: byte reception, acknowledge and transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR_WR;
            shreg   <= 8'h00;
            bitcnt  <= 4'd0;
            idx     <= '0;
            pec_lat <= 1'b0;
            oe_q    <= 1'b0;
        end else if (stop_p) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
        end else if (start_p) begin
            state  <= ST_RX;
            bitcnt <= 4'd0;
            idx    <= '0;
            oe_q   <= 1'b0;
            if (state == ST_WAIT_SR) begin
                phase <= PH_ADDR_RD;
            end else begin
                phase   <= PH_ADDR_WR;
                pec_lat <= pec_en;
            end
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && (bitcnt < 4'd8)) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && (bitcnt == 4'd8)) begin
                        if (rx_ok) begin
                            oe_q  <= 1'b1;
                            state <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        case (phase)
                            PH_ADDR_WR: begin
                                phase  <= PH_CMD;
                                state  <= ST_RX;
                                bitcnt <= 4'd0;
                                oe_q   <= 1'b0;
                            end
                            PH_CMD: begin
                                state <= ST_WAIT_SR;
                                oe_q  <= 1'b0;
                            end
                            default: begin
                                state  <= ST_TX;
                                shreg  <= COUNT_BYTE;
                                oe_q   <= ~COUNT_BYTE[7];
                                idx    <= IDX_W'(1);
                                bitcnt <= 4'd0;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            oe_q  <= 1'b0;
                            state <= ST_HACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            oe_q  <= ~shreg[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        if (sda_s || (idx == idx_final)) state <= ST_IDLE;
                        else                             state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (scl_fall) begin
                        shreg  <= next_byte;
                        oe_q   <= ~next_byte[7];
                        idx    <= idx + 1'b1;
                        bitcnt <= 4'd0;
                        state  <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: drive changes only during the low clock phase.
    p_sda_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> !scl_s);

    // R10: a stop always leaves the line released.
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !oe_q);

    // R12: opening start clears the CRC remainder.
    p_crc_open_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && (state != ST_WAIT_SR)) |=> (crc_q == 8'h00));

    // R9: refused or finished transactions never drive the line.
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !oe_q);

    // R5: the first transmitted byte is the count.
    p_count_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TX) && ($past(state) == ST_ACK)) |-> (shreg == COUNT_BYTE));

endmodule

// File: tb/smb_blkrd_target_test.sv
`timescale 1ns/1ps
module smb_blkrd_target_test;

    localparam int N = 32;
    localparam int Q = 6;   // quarter of an SCL period, in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] own = 7'h3A;
    logic       pec_en = 1'b0;
    logic [4:0] rd_addr;
    logic [7:0] rd_data;
    logic [7:0] mem [N];

    int checks = 0;
    int errors = 0;
    int hi_changes = 0;
    logic oe_prev = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_h & ~sda_oe;
    assign rd_data = mem[rd_addr];

    smb_blkrd_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_h),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .own_addr (own),
        .pec_en   (pec_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // R11 monitor: drive must not move while the bus clock is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_h) hi_changes++;
        oe_prev <= sda_oe;
    end

    task automatic check(input string msg, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) r = (r[7] ^ d[i]) ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic fill(input int p);
        for (int i = 0; i < N; i++) begin
            case (p)
                0: mem[i] = 8'(i);
                1: mem[i] = 8'(255 - i * 7);
                2: mem[i] = 8'(i * 37 + 11);
                default: mem[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
            endcase
        end
    endtask

    task automatic bus_start();
        scl_h = 1'b0; wq(Q);
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(2 * Q);
        sda_h = 1'b0; wq(2 * Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        scl_h = 1'b0; wq(Q);
        sda_h = 1'b0; wq(Q);
        scl_h = 1'b1; wq(Q);
        sda_h = 1'b1; wq(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;    wq(Q);
        scl_h = 1'b1; wq(2 * Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_h = 1'b1; wq(Q);
            b[i] = sda_bus;
            wq(Q);
            scl_h = 1'b0; wq(Q);
        end
        put_bit(!ack);
        sda_h = 1'b1;
    endtask

    // Opening phase up to and including the read-address acknowledge.
    task automatic open_read(output logic [7:0] c);
        logic a;
        c = 8'h00;
        bus_start();
        send_byte({own, 1'b0}, a); check("R2 write address ACK", 16'(a), 16'd1);
        c = crc_b(c, {own, 1'b0});
        send_byte(8'hFD, a);       check("R3 command ACK", 16'(a), 16'd1);
        c = crc_b(c, 8'hFD);
        bus_start();
        send_byte({own, 1'b1}, a); check("R4 read address ACK", 16'(a), 16'd1);
        c = crc_b(c, {own, 1'b1});
    endtask

    task automatic do_read(input logic pec);
        logic [7:0] b, c;
        pec_en = pec;
        open_read(c);
        recv_byte(b, 1'b1); check("R5 byte count", 16'(b), 16'h20);
        c = crc_b(c, 8'h20);
        for (int k = 0; k < N; k++) begin
            recv_byte(b, pec || (k != N - 1));
            check($sformatf("R6 data byte %0d", k), 16'(b), 16'(mem[k]));
            c = crc_b(c, mem[k]);
        end
        recv_byte(b, 1'b0);
        if (pec) check("R7 R12 PEC byte", 16'(b), 16'(c));
        else     check("R8 nothing after last data", 16'(b), 16'hFF);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b, c;
        fill(0);
        wq(10);
        check("R1 reset sda_oe", 16'(sda_oe), 16'd0);
        rst_n = 1'b1;
        wq(5);
        check("R1 idle sda_oe", 16'(sda_oe), 16'd0);
        check("R1 idle rd_addr", 16'(rd_addr), 16'd0);

        // R2: sweep every write address; only own_addr is acknowledged.
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            check($sformatf("R2 address %0h", ad), 16'(a), 16'(ad == int'(own)));
            bus_stop();
        end
        // R2: read direction in the opening phase, then silence after a miss.
        bus_start();
        send_byte({own, 1'b1}, a); check("R2 R/W high refused", 16'(a), 16'd0);
        bus_stop();
        bus_start();
        send_byte({own ^ 7'h01, 1'b0}, a); check("R2 mismatch NACK", 16'(a), 16'd0);
        send_byte(8'hFD, a);               check("R2 silent after mismatch", 16'(a), 16'd0);
        bus_stop();

        // R3: command sweep; rejection persists through the repeated start.
        for (int cm = 0; cm < 18; cm++) begin
            logic [7:0] code = (cm < 16) ? 8'(8'hF0 + cm) : ((cm == 16) ? 8'h00 : 8'h7D);
            bus_start();
            send_byte({own, 1'b0}, a);
            send_byte(code, a);
            check($sformatf("R3 command %0h", code), 16'(a), 16'(code == 8'hFD));
            if (code != 8'hFD) begin
                bus_start();
                send_byte({own, 1'b1}, a);
                check("R3 silent after bad command", 16'(a), 16'd0);
            end
            bus_stop();
        end

        // R4: wrong read address and wrong direction after repeated start.
        for (int v = 0; v < 2; v++) begin
            bus_start();
            send_byte({own, 1'b0}, a);
            send_byte(8'hFD, a);
            bus_start();
            send_byte((v == 0) ? {own ^ 7'h10, 1'b1} : {own, 1'b0}, a);
            check("R4 read address refused", 16'(a), 16'd0);
            bus_stop();
        end

        // R5..R8, R12: full reads over several patterns, PEC on and off.
        for (int p = 0; p < 4; p++) begin
            fill(p);
            do_read(p[0] == 1'b0);
        end

        // R9: early host NACK after data byte 4.
        fill(2);
        pec_en = 1'b1;
        open_read(c);
        recv_byte(b, 1'b1);
        for (int k = 0; k < 5; k++) begin
            recv_byte(b, k != 4);
            check("R9 data before NACK", 16'(b), 16'(mem[k]));
        end
        recv_byte(b, 1'b0); check("R9 released after NACK", 16'(b), 16'hFF);
        bus_stop();

        // R10: stop in mid-response while the current bit is a one.
        fill(1);
        mem[3] = 8'hA5;
        open_read(c);
        recv_byte(b, 1'b1);
        for (int k = 0; k < 3; k++) recv_byte(b, 1'b1);
        bus_stop();
        wq(4);
        check("R10 released after stop", 16'(sda_oe), 16'd0);
        do_read(1'b1);

        // R10: start in mid-response opens a fresh transaction.
        open_read(c);
        recv_byte(b, 1'b1);
        for (int k = 0; k < 3; k++) recv_byte(b, 1'b1);
        do_read(1'b1);

        check("R11 drive changes during SCL high", 16'(hi_changes), 16'd0);
        finish_run();
    end

endmodule